// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins that software reaches through a small word-addressed register bus. Each pin owns one bit in four registers: an output value, a direction select, an interrupt enable and a sticky event register. Pin inputs are brought into the clock domain by a two-stage synchroniser before they are read or examined for edges. The block drives a separate tri-state enable for each pin and one combined interrupt line.

The interrupt trigger is chosen when the block is built, not by software. It can be rising edge, falling edge, either edge, or level-high. In the three edge modes a qualifying transition sets the pin's event bit, which stays set until software writes a one to it. The interrupt is then the OR of the event bits with their enables. In level-high mode the event register is unused and reads zero, and the interrupt follows the synchronised pin levels gated by the enables.

Top module: `gpio_mmio_port`

## Requirements
- R1: Reset, synchronous and active low, clears the output, direction, enable and event registers. After reset every register reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq` is low.
- R2: Address bits [3:2] select the register: byte offset 0x0 is data, 0x4 is direction, 0x8 is interrupt enable and 0xC is the event register. Direction and enable read back as written. Bits at or above `PIN_COUNT` read as 0 in every register.
- R3: `pin_oe` equals the direction register, where 1 makes a pin an output. `pin_out` equals the written output value. Both take the new value at the clock edge that accepts the write.
- R4: A read of offset 0x0 returns the synchronised pin level. A pin change made before clock edge k is returned after edge k+1 and not after edge k.
- R5: In edge modes an event bit is set at the third clock edge after the pin change. A rising mode sets it on 0-to-1, a falling mode on 1-to-0, and the either-edge mode on both. A transition of the other kind sets nothing. The bit stays set until it is cleared.
- R6: A write to offset 0xC clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R7: In edge modes `irq` is high exactly when some event bit and its enable bit are both 1, from the edge that changes either one. Changing an enable does not change the event bits.
- R8: In level-high mode `irq` is high when some synchronised pin level and its enable bit are both 1, which is two edges after the pin change. The event register always reads 0 in this mode.
- R9: If a qualifying edge and a write-one-to-clear of the same bit meet at the same clock edge, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output values for the pins |
| pin_oe | output | PIN_COUNT | Per-pin output enable (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the accepting edge, so the bench samples `pin_oe`, `pin_out`, `irq` and read-back values at the next falling edge. A pin change shows up in the data register two rising edges later, in the event register three edges later, and in a level-mode interrupt two edges later. The directed tests sample one edge early and then on time to prove this latency. The race test puts the clearing write exactly on the third edge after a pin change, so the edge and the clear meet in the same cycle. Four instances, one per trigger mode, share the bus and the pins, which lets one transition be compared across all modes.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: trigger modes, register selects
// and the bus data width. Assumes a 32-bit data bus.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam int unsigned BUS_DW = 32;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_DIR  = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_CAPT = 2'd3;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the pin inputs, plus a third stage holding the
// synchronised value one clock earlier for edge detection.
// Assumes pins are asynchronous single-bit signals, each independent.
module gpio_in_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_async,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] level_prev_q
);
    logic [WIDTH-1:0] meta_q;

    // Shift pins through the metastability stage, the level stage and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q       <= '0;
            level_q      <= '0;
            level_prev_q <= '0;
        end else begin
            meta_q       <= pins_async;
            level_q      <= meta_q;
            level_prev_q <= level_q;
        end
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Software-written control registers: output value, direction and
// interrupt enable. Assumes write enables are decoded and one-hot per write.
module gpio_ctrl_regs #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_out_en,
    input  logic             wr_dir_en,
    input  logic             wr_mask_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] mask_q
);
    // Load each register from the bus when its write enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_out_en)  out_q  <= wdata;
            if (wr_dir_en)  dir_q  <= wdata;
            if (wr_mask_en) mask_q <= wdata;
        end
    end

    // R1: the first cycle after reset shows every control register cleared.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_q == '0 && dir_q == '0 && mask_q == '0));

    // R3: a direction write is visible on the following cycle.
    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_capture.sv
// Event register for the edge trigger modes. A build-time parameter picks
// the edge kind. Bits set on a qualifying edge and clear on a written one.
// An edge beats a clear in the same cycle. In level mode the register is
// absent and reads zero.
module gpio_capture
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter trig_e       TRIGGER = TRIG_BOTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] level_prev,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] cap_q
);
    if (TRIGGER == TRIG_LEVEL) begin : g_level
        assign cap_q = '0;
        logic unused_lvl;
        assign unused_lvl = ^{clk, rst_n, level, level_prev, clr_en, clr_bits};
    end else begin : g_edge
        logic [WIDTH-1:0] evt;
        logic [WIDTH-1:0] clr_vec;
        logic [WIDTH-1:0] cap_r;

        if (TRIGGER == TRIG_RISE) begin : g_rise
            assign evt = level & ~level_prev;
        end else if (TRIGGER == TRIG_FALL) begin : g_fall
            assign evt = ~level & level_prev;
        end else begin : g_both
            assign evt = level ^ level_prev;
        end

        assign clr_vec = clr_en ? clr_bits : '0;

        // Hold set bits, drop the cleared ones, then OR in new events so an edge wins.
        always_ff @(posedge clk) begin
            if (!rst_n) cap_r <= '0;
            else        cap_r <= (cap_r & ~clr_vec) | evt;
        end

        assign cap_q = cap_r;

        // R9: a detected edge always leaves its bit set, even with a clear pending.
        a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (evt != '0) |=> ((cap_r & $past(evt)) == $past(evt)));

        // R6: a cleared bit with no coincident edge is zero next cycle.
        a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en |=> ((cap_r & $past(clr_bits & ~evt)) == '0));

        // R5: bits never fall except where a clear was written.
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(cap_r) & ~cap_r & ~$past(clr_vec)) == '0));
    end
endmodule

// File: rtl/gpio_mmio_port.sv
// Top level of the register-mapped GPIO port. Decodes the word-addressed
// bus, muxes the read data and forms the combined interrupt for the
// build-time trigger mode. Assumes PIN_COUNT is between 1 and 32 and that
// reads have no side effects.
module gpio_mmio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32,
    parameter trig_e       TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [3:0]           bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam int unsigned W = PIN_COUNT;

    logic [1:0]   sel;
    logic         wr;
    logic [W-1:0] wbits;
    logic [W-1:0] lvl, lvl_prev;
    logic [W-1:0] out_q, dir_q, mask_q, cap_q;

    assign sel   = bus_addr[3:2];
    assign wr    = bus_valid && bus_write;
    assign wbits = bus_wdata[W-1:0];

    logic unused_lo;
    assign unused_lo = ^bus_addr[1:0];
    if (W < BUS_DW) begin : g_pad
        logic unused_hi;
        assign unused_hi = ^bus_wdata[BUS_DW-1:W];
    end

    gpio_in_sync #(.WIDTH(W)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_async   (pin_in),
        .level_q      (lvl),
        .level_prev_q (lvl_prev)
    );

    gpio_ctrl_regs #(.WIDTH(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_out_en  (wr && sel == SEL_DATA),
        .wr_dir_en  (wr && sel == SEL_DIR),
        .wr_mask_en (wr && sel == SEL_MASK),
        .wdata      (wbits),
        .out_q      (out_q),
        .dir_q      (dir_q),
        .mask_q     (mask_q)
    );

    gpio_capture #(.WIDTH(W), .TRIGGER(TRIGGER)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (lvl),
        .level_prev (lvl_prev),
        .clr_en     (wr && sel == SEL_CAPT),
        .clr_bits   (wbits),
        .cap_q      (cap_q)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // Select the addressed register and zero-extend it to the bus width.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DATA: bus_rdata[W-1:0] = lvl;
            SEL_DIR:  bus_rdata[W-1:0] = dir_q;
            SEL_MASK: bus_rdata[W-1:0] = mask_q;
            default:  bus_rdata[W-1:0] = cap_q;
        endcase
    end

    if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
        assign irq = |(lvl & mask_q);
    end else begin : g_irq_edge
        assign irq = |(cap_q & mask_q);
    end
endmodule

// File: tb/sim_gpio_mmio_port.sv
module sim_gpio_mmio_port;
    import gpio_port_pkg::*;

    localparam int unsigned NP = 20;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Register-map walk on u0 (either-edge mode), 20 pins.
    // R2 entries: read-back and clipping above bit 19. R4: data loop-back.
    // R5/R6: event bits from the data pattern, then cleared by writing ones.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0,        4'd2},
        '{1'b0, 4'h4, 32'h0,         32'h000F_FFFF, 4'd2},
        '{1'b1, 4'h8, 32'hA5A5_A5A5, 32'h0,        4'd2},
        '{1'b0, 4'h8, 32'h0,         32'h0005_A5A5, 4'd2},
        '{1'b1, 4'h0, 32'hFFF1_2345, 32'h0,        4'd4},
        '{1'b0, 4'h0, 32'h0,         32'h0001_2345, 4'd4},
        '{1'b1, 4'h4, 32'h0,         32'h0,        4'd2},
        '{1'b0, 4'h4, 32'h0,         32'h0,        4'd2},
        '{1'b1, 4'h8, 32'h0,         32'h0,        4'd2},
        '{1'b0, 4'h8, 32'h0,         32'h0,        4'd2},
        '{1'b0, 4'hC, 32'h0,         32'h0001_2345, 4'd5},
        '{1'b1, 4'hC, 32'h0000_0345, 32'h0,        4'd6},
        '{1'b0, 4'hC, 32'h0,         32'h0001_2000, 4'd6},
        '{1'b1, 4'hC, 32'hFFFF_FFFF, 32'h0,        4'd6},
        '{1'b0, 4'hC, 32'h0,         32'h0,        4'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bv = 1'b0, bw = 1'b0;
    logic [3:0]  ba = '0;
    logic [31:0] bd = '0;
    logic [NP-1:0] ext = '0;

    logic [31:0]   rd0, rd1, rd2, rd3;
    logic [NP-1:0] out0, out1, out2, out3;
    logic [NP-1:0] oe0, oe1, oe2, oe3;
    logic          irq0, irq1, irq2, irq3;
    logic [31:0]   r0, r1, r2, r3;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_mmio_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_BOTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(rd0), .pin_in((oe0 & out0) | (~oe0 & ext)),
        .pin_out(out0), .pin_oe(oe0), .irq(irq0));
    gpio_mmio_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_RISE)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(rd1), .pin_in((oe1 & out1) | (~oe1 & ext)),
        .pin_out(out1), .pin_oe(oe1), .irq(irq1));
    gpio_mmio_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_FALL)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(rd2), .pin_in((oe2 & out2) | (~oe2 & ext)),
        .pin_out(out2), .pin_oe(oe2), .irq(irq2));
    gpio_mmio_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_LEVEL)) u3 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(rd3), .pin_in((oe3 & out3) | (~oe3 & ext)),
        .pin_out(out3), .pin_oe(oe3), .irq(irq3));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bv = 1'b1; bw = 1'b1; ba = a; bd = d;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a);
        @(negedge clk);
        bv = 1'b1; bw = 1'b0; ba = a;
        #1;
        r0 = rd0; r1 = rd1; r2 = rd2; r3 = rd3;
        bv = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        bus_rd(4'h4); chk("R1 dir after reset", r0, 32'h0);
        bus_rd(4'h8); chk("R1 mask after reset", r0, 32'h0);
        bus_rd(4'hC); chk("R1 capture after reset", r0, 32'h0);
        chk("R1 pin_oe after reset", {12'h0, oe0}, 32'h0);
        chk("R1 pin_out after reset", {12'h0, out0}, 32'h0);
        chk("R1 irq after reset", {28'h0, irq3, irq2, irq1, irq0}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
            else begin
                bus_rd(VECS[i].addr);
                chk($sformatf("R%0d table %0d", VECS[i].req, i), r0, VECS[i].exp);
            end
            idle(3);
        end

        // R3: direction drives pin_oe, data register drives pin_out, next cycle
        bus_wr(4'h0, 32'h0000_00A5);
        chk("R3 pin_out", {12'h0, out0}, 32'h0000_00A5);
        bus_wr(4'h4, 32'h0000_000F);
        chk("R3 pin_oe", {12'h0, oe0}, 32'h0000_000F);
        idle(4);
        bus_wr(4'h4, 32'h0);
        idle(4);
        bus_wr(4'hC, 32'hFFFF_FFFF);
        idle(2);

        // R4: data latency is two edges
        ext[7] = 1'b1;
        @(negedge clk);
        #1 ba = 4'h0; #1 chk("R4 data one edge early", rd0 & 32'h80, 32'h0);
        @(negedge clk);
        #1 chk("R4 data after two edges", rd0 & 32'h80, 32'h80);
        // R5: event register not yet set after two edges
        ba = 4'hC; #1 chk("R5 capture not yet set", rd0 & 32'h80, 32'h0);
        @(negedge clk);
        #1;
        chk("R5 both-edge captures rise", rd0 & 32'h80, 32'h80);
        chk("R5 rise mode captures rise", rd1 & 32'h80, 32'h80);
        chk("R5 fall mode ignores rise", rd2 & 32'h80, 32'h0);
        chk("R8 level mode capture reads zero", rd3, 32'h0);
        ext[7] = 1'b0;
        idle(3);
        bus_rd(4'hC);
        chk("R5 fall mode captures fall", r2 & 32'h80, 32'h80);

        // R7: enable drives irq from existing events; capture untouched
        chk("R7 irq masked", {31'h0, irq0}, 32'h0);
        bus_wr(4'h8, 32'h80);
        chk("R7 irq both-edge", {31'h0, irq0}, 32'h1);
        chk("R7 irq rise", {31'h0, irq1}, 32'h1);
        chk("R7 irq fall", {31'h0, irq2}, 32'h1);
        chk("R8 level irq low while pin low", {31'h0, irq3}, 32'h0);
        bus_rd(4'hC);
        chk("R7 enable keeps capture", r0 & 32'h80, 32'h80);

        // R8: level irq after two edges
        ext[7] = 1'b1;
        @(negedge clk);
        #1 chk("R8 level irq one edge early", {31'h0, irq3}, 32'h0);
        @(negedge clk);
        #1 chk("R8 level irq after two edges", {31'h0, irq3}, 32'h1);
        idle(3);
        bus_wr(4'hC, 32'h80);
        chk("R6 clear drops irq", {31'h0, irq0}, 32'h0);
        chk("R8 level irq ignores capture write", {31'h0, irq3}, 32'h1);
        ext[7] = 1'b0;
        idle(3);
        chk("R8 level irq follows pin low", {31'h0, irq3}, 32'h0);
        bus_wr(4'h8, 32'h0);
        bus_wr(4'hC, 32'hFFFF_FFFF);
        idle(2);

        // R9: edge and clear meet in the same cycle
        ext[6:5] = 2'b11;
        idle(4);
        bus_rd(4'hC);
        chk("R9 setup both bits set", r0 & 32'h60, 32'h60);
        ext[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bv = 1'b1; bw = 1'b1; ba = 4'hC; bd = 32'h60;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
        bus_rd(4'hC);
        chk("R9 edge beats clear", r0 & 32'h60, 32'h20);
        chk("R9 rise mode cleared", r1 & 32'h60, 32'h0);

        // R1: reset mid-run
        bus_wr(4'h4, 32'h3);
        bus_wr(4'h8, 32'hFF);
        ext = '0;
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        bus_rd(4'h4); chk("R1 dir after second reset", r0, 32'h0);
        bus_rd(4'h8); chk("R1 mask after second reset", r0, 32'h0);
        bus_rd(4'hC); chk("R1 capture after second reset", r0, 32'h0);
        chk("R1 pin_oe after second reset", {12'h0, oe0}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule